// File: doc/BRIEF.md
# Processor Status and Control Flag Unit

This block keeps the 16-bit flag word of a small processor. Each time the datapath finishes an ALU operation it presents the operand width (byte or word), the operation class, both operands and the result. When the update strobe is high, the block captures carry, auxiliary carry, parity, zero, sign and overflow for that operation on the next clock edge. While the strobe is low, those six flags keep their values.

Three control flags live in the same word: single-step trap, interrupt enable and string direction. Each has its own set and clear command lines, and status updates never touch them. The control flags drive three outputs. The interrupt-enable flag gates an external maskable interrupt request. The trap flag raises a single-step request each time an instruction completes. The direction flag tells the string address logic whether index pointers step down or up.

Top module: `flag_unit`

## Requirements
- R1: An active-low asynchronous reset clears the whole flag word to 0000h.
- R2: Carry (bit 0) is updated from the operand width selected by `wide` (0 = low 8 bits, 1 = all 16 bits). For `op_cls` 00 (add) it is set when the sum carries out of the most significant bit of that width. For 01 (subtract, `opa` minus `opb`) it is set when the subtraction needs a borrow. For 10 and 11 (logical) it is cleared.
- R3: Auxiliary carry (bit 4) is set for an add that carries from bit 3 into bit 4, and for a subtract that borrows into bit 3 from bit 4. It is cleared for logical operations.
- R4: Parity (bit 2) is 1 when `res[7:0]` holds an even number of ones and 0 when the count is odd, for byte and word operations alike.
- R5: Zero (bit 6) is set when the result is all zeros within the selected width. Sign (bit 7) takes the most significant result bit of that width (bit 7 for bytes, bit 15 for words). Bits above the selected width of operands and result have no effect.
- R6: Overflow (bit 11) is set for an add whose operands share a sign that the result does not have. It is set for a subtract whose operand signs differ and whose result sign differs from `opa`. It is cleared for logical operations.
- R7: With `upd_en` low, the six status flags keep their values whatever the operands, result and class are.
- R8: Control command index 0 is trap (bit 8), index 1 is interrupt enable (bit 9) and index 2 is direction (bit 10). A set line sets its flag on the next edge and a clear line clears it. Clear wins when both are high. Status updates leave these flags unchanged.
- R9: `irq_accept` follows `irq_in` while interrupt enable is 1 and stays 0 while it is 0.
- R10: `step_trap` is high in a cycle where `instr_done` is high and trap is 1. It is low whenever trap is 0.
- R11: `dir_down` equals the direction flag: 0 means the index pointers step up, 1 means they step down.
- R12: Bits 1, 3, 5 and 12 to 15 of the flag word always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_en | input | 1 | Capture status flags from this cycle's operation |
| wide | input | 1 | 0 = byte operation, 1 = word operation |
| op_cls | input | 2 | 00 add, 01 subtract, 10/11 logical |
| opa | input | 16 | First operand (minuend for subtract) |
| opb | input | 16 | Second operand |
| res | input | 16 | ALU result |
| ctl_set | input | 3 | Set commands for trap, interrupt enable, direction |
| ctl_clr | input | 3 | Clear commands, same order as the set commands |
| irq_in | input | 1 | External maskable interrupt request |
| instr_done | input | 1 | An instruction completed this cycle |
| flags | output | 16 | Flag word |
| irq_accept | output | 1 | Gated interrupt request |
| step_trap | output | 1 | Single-step interrupt request |
| dir_down | output | 1 | String pointer step direction |

## Verification
The checker watches several properties on every cycle:
- the interrupt gate and the single-step gate,
- the direction output,
- the unused bits staying zero,
- the status flags holding while `upd_en` is low,
- logical operations clearing carry and overflow,
- zero following an all-zero result,
- set and clear commands taking effect on control flags.

The exact carry, auxiliary-carry, parity, sign and overflow values need operand patterns with known answers, so only the bench's vectors can show them. These include sign-boundary additions, borrows at nibble and word limits, and byte operations with junk in the upper bits. The same holds for clear winning over set and for reset in the middle of a run.

// File: rtl/flag_unit_pkg.sv
package flag_unit_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int CTL_N  = 3;

  // Flag word bit positions
  localparam int BIT_C = 0;
  localparam int BIT_P = 2;
  localparam int BIT_A = 4;
  localparam int BIT_Z = 6;
  localparam int BIT_S = 7;
  localparam int BIT_T = 8;
  localparam int BIT_I = 9;
  localparam int BIT_D = 10;
  localparam int BIT_O = 11;

  // Control command indices
  localparam int CTL_TRAP = 0;
  localparam int CTL_IEN  = 1;
  localparam int CTL_DIR  = 2;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_LOG  = 2'b10,
    OP_LOG2 = 2'b11
  } op_cls_e;

  typedef struct packed {
    logic cf;
    logic pf;
    logic af;
    logic zf;
    logic sf;
    logic of;
  } status_t;

  function automatic logic [DATA_W-1:0] width_mask(input logic wide);
    return wide ? {DATA_W{1'b1}} : {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  endfunction

  // Carry out of (add) or borrow into (sub) the top bit of the selected width
  function automatic logic carry_fn(input logic wide, input logic sub,
                                    input logic [DATA_W-1:0] a,
                                    input logic [DATA_W-1:0] b);
    logic [DATA_W:0]   ext;
    logic [DATA_W-1:0] m;
    m   = width_mask(wide);
    ext = sub ? ({1'b0, a & m} - {1'b0, b & m})
              : ({1'b0, a & m} + {1'b0, b & m});
    return wide ? ext[DATA_W] : ext[BYTE_W];
  endfunction

  function automatic logic nibble_carry(input logic sub,
                                        input logic [NIB_W-1:0] a,
                                        input logic [NIB_W-1:0] b);
    logic [NIB_W:0] ext;
    ext = sub ? ({1'b0, a} - {1'b0, b}) : ({1'b0, a} + {1'b0, b});
    return ext[NIB_W];
  endfunction

  function automatic logic even_ones(input logic [BYTE_W-1:0] v);
    return ~(^v);
  endfunction

  function automatic logic signed_ovf(input logic is_add, input logic is_sub,
                                      input logic sa, input logic sb,
                                      input logic sr);
    return (is_add & (sa == sb) & (sr != sa)) |
           (is_sub & (sa != sb) & (sr != sa));
  endfunction
endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flag_unit_pkg::*;
(
  input  logic              wide,
  input  logic [1:0]        op_cls,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  output status_t           st
);
  logic              is_add;
  logic              is_sub;
  logic              is_arith;
  logic [DATA_W-1:0] res_m;
  logic              msb_a;
  logic              msb_b;
  logic              msb_r;

  always_comb begin
    is_add   = (op_cls == OP_ADD);
    is_sub   = (op_cls == OP_SUB);
    is_arith = is_add | is_sub;
    res_m    = res & width_mask(wide);
    msb_a    = wide ? opa[DATA_W-1] : opa[BYTE_W-1];
    msb_b    = wide ? opb[DATA_W-1] : opb[BYTE_W-1];
    msb_r    = wide ? res[DATA_W-1] : res[BYTE_W-1];

    st.cf = is_arith & carry_fn(wide, is_sub, opa, opb);
    st.af = is_arith & nibble_carry(is_sub, opa[NIB_W-1:0], opb[NIB_W-1:0]);
    st.pf = even_ones(res[BYTE_W-1:0]);
    st.zf = (res_m == '0);
    st.sf = msb_r;
    st.of = signed_ovf(is_add, is_sub, msb_a, msb_b, msb_r);
  end
endmodule

// File: rtl/status_reg.sv
module status_reg
  import flag_unit_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    upd_en,
  input  status_t st_d,
  output status_t st_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= '0;
    else if (upd_en) st_q <= st_d;
  end
endmodule

// File: rtl/ctl_flags.sv
module ctl_flags
  import flag_unit_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_N-1:0] set_cmd,
  input  logic [CTL_N-1:0] clr_cmd,
  output logic [CTL_N-1:0] q
);
  for (genvar i = 0; i < CTL_N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (clr_cmd[i]) q[i] <= 1'b0;
      else if (set_cmd[i]) q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/flag_unit.sv
module flag_unit
  import flag_unit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic              wide,
  input  logic [1:0]        op_cls,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] res,
  input  logic [CTL_N-1:0]  ctl_set,
  input  logic [CTL_N-1:0]  ctl_clr,
  input  logic              irq_in,
  input  logic              instr_done,
  output logic [DATA_W-1:0] flags,
  output logic              irq_accept,
  output logic              step_trap,
  output logic              dir_down
);
  status_t          st_next;
  status_t          st_q;
  logic [CTL_N-1:0] ctl_q;

  flag_calc u_calc (
    .wide   (wide),
    .op_cls (op_cls),
    .opa    (opa),
    .opb    (opb),
    .res    (res),
    .st     (st_next)
  );

  status_reg u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .upd_en (upd_en),
    .st_d   (st_next),
    .st_q   (st_q)
  );

  ctl_flags u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_cmd (ctl_set),
    .clr_cmd (ctl_clr),
    .q       (ctl_q)
  );

  always_comb begin
    flags        = '0;
    flags[BIT_C] = st_q.cf;
    flags[BIT_P] = st_q.pf;
    flags[BIT_A] = st_q.af;
    flags[BIT_Z] = st_q.zf;
    flags[BIT_S] = st_q.sf;
    flags[BIT_O] = st_q.of;
    flags[BIT_T] = ctl_q[CTL_TRAP];
    flags[BIT_I] = ctl_q[CTL_IEN];
    flags[BIT_D] = ctl_q[CTL_DIR];
  end

  assign irq_accept = irq_in & ctl_q[CTL_IEN];
  assign step_trap  = instr_done & ctl_q[CTL_TRAP];
  assign dir_down   = ctl_q[CTL_DIR];
endmodule

// File: rtl/flag_unit_chk.sv
module flag_unit_chk
  import flag_unit_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              upd_en,
  input logic              wide,
  input logic [1:0]        op_cls,
  input logic [DATA_W-1:0] res,
  input logic [CTL_N-1:0]  ctl_set,
  input logic [CTL_N-1:0]  ctl_clr,
  input logic              irq_in,
  input logic              instr_done,
  input logic [DATA_W-1:0] flags,
  input logic              irq_accept,
  input logic              step_trap,
  input logic              dir_down
);
  localparam logic [DATA_W-1:0] STAT_MASK   = 16'h08D5;
  localparam logic [DATA_W-1:0] UNUSED_MASK = 16'hF02A;

  logic [DATA_W-1:0] res_sel;
  assign res_sel = wide ? res : {{(DATA_W-BYTE_W){1'b0}}, res[BYTE_W-1:0]};

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[BIT_I] |-> !irq_accept);                                // R9
  AST_IRQ_PASSED: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[BIT_I] && irq_in) |-> irq_accept);                      // R9
  AST_TRAP_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[BIT_T] && instr_done) |-> step_trap);                   // R10
  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !flags[BIT_T] |-> !step_trap);                                 // R10
  AST_DIR_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    dir_down == flags[BIT_D]);                                     // R11
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & UNUSED_MASK) == '0);                                  // R12
  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flags & STAT_MASK));                       // R7
  AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_cls[1]) |=> (!flags[BIT_C] && !flags[BIT_O]));   // R6
  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && res_sel == '0) |=> flags[BIT_Z]);                   // R5
  AST_CTL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_clr[CTL_TRAP] |=> !flags[BIT_T]);                          // R8
  AST_CTL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_set[CTL_IEN] && !ctl_clr[CTL_IEN]) |=> flags[BIT_I]);     // R8
endmodule

bind flag_unit flag_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .upd_en     (upd_en),
  .wide       (wide),
  .op_cls     (op_cls),
  .res        (res),
  .ctl_set    (ctl_set),
  .ctl_clr    (ctl_clr),
  .irq_in     (irq_in),
  .instr_done (instr_done),
  .flags      (flags),
  .irq_accept (irq_accept),
  .step_trap  (step_trap),
  .dir_down   (dir_down)
);

// File: tb/sim_flag_unit.sv
module sim_flag_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  // {wide, op_cls, opa, opb, res, expected flag word}
  localparam logic [66:0] VEC [NV] = '{
    {1'b0, 2'b00, 16'h0080, 16'h0080, 16'h0000, 16'h0845}, // byte add 80+80
    {1'b0, 2'b01, 16'h0080, 16'h0080, 16'h0000, 16'h0044}, // byte sub 80-80
    {1'b0, 2'b00, 16'h000F, 16'h0001, 16'h0010, 16'h0010}, // nibble carry
    {1'b1, 2'b00, 16'h7FFF, 16'h0001, 16'h8000, 16'h0894}, // word signed ovf
    {1'b1, 2'b01, 16'h0000, 16'h0001, 16'hFFFF, 16'h0095}, // word borrow
    {1'b1, 2'b10, 16'hF0F0, 16'h0FF0, 16'h00F0, 16'h0004}, // word logic
    {1'b0, 2'b10, 16'h0000, 16'h0000, 16'hFF07, 16'h0000}, // byte logic, junk high
    {1'b0, 2'b10, 16'h0000, 16'h0000, 16'hAB00, 16'h0044}, // byte zero, junk high
    {1'b1, 2'b01, 16'h8000, 16'h0001, 16'h7FFF, 16'h0814}, // word sub ovf
    {1'b0, 2'b00, 16'h12FF, 16'h3401, 16'h4600, 16'h0055}, // byte add junk high
    {1'b0, 2'b11, 16'h0001, 16'h0001, 16'h0081, 16'h0084}  // class 11 as logic
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic        wide = 1'b0;
  logic [1:0]  op_cls = 2'b00;
  logic [15:0] opa = '0, opb = '0, res = '0;
  logic [2:0]  ctl_set = '0, ctl_clr = '0;
  logic        irq_in = 1'b0, instr_done = 1'b0;
  logic [15:0] flags;
  logic        irq_accept, step_trap, dir_down;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .wide(wide), .op_cls(op_cls),
    .opa(opa), .opb(opb), .res(res), .ctl_set(ctl_set), .ctl_clr(ctl_clr),
    .irq_in(irq_in), .instr_done(instr_done), .flags(flags),
    .irq_accept(irq_accept), .step_trap(step_trap), .dir_down(dir_down)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive control command for one edge
  task automatic ctl_cmd(input logic [2:0] s, input logic [2:0] c);
    @(negedge clk);
    ctl_set = s; ctl_clr = c;
    @(negedge clk);
    ctl_set = '0; ctl_clr = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    irq_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset flag word", flags, 16'h0000);
    chk("R9 irq blocked at reset", {15'b0, irq_accept}, 16'h0000);
    rst_n = 1'b1;
    irq_in = 1'b0;

    // Vector walk: R2 R3 R4 R5 R6 status flags
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {wide, op_cls, opa, opb, res} = VEC[i][66:16];
      upd_en = 1'b1;
      @(negedge clk);
      upd_en = 1'b0;
      chk($sformatf("R2 R3 R4 R5 R6 vector %0d", i), flags, VEC[i][15:0]);
    end

    // R7: hold while update strobe low (last vector gave 0084h)
    wide = 1'b1; op_cls = 2'b00; opa = 16'hFFFF; opb = 16'h0001; res = 16'h0000;
    repeat (2) @(negedge clk);
    chk("R7 status hold", flags, 16'h0084);

    // R8/R9: set interrupt enable
    ctl_cmd(3'b010, 3'b000);
    chk("R8 ien set", flags, 16'h0284);
    irq_in = 1'b1; #1;
    chk("R9 irq passed", {15'b0, irq_accept}, 16'h0001);
    irq_in = 1'b0; #1;
    chk("R9 irq idle", {15'b0, irq_accept}, 16'h0000);

    // R8: status update leaves control flags alone
    @(negedge clk);
    wide = 1'b0; op_cls = 2'b01; opa = 16'h0080; opb = 16'h0080; res = 16'h0000;
    upd_en = 1'b1;
    @(negedge clk);
    upd_en = 1'b0;
    chk("R8 ctl kept over update", flags, 16'h0244);

    // R8: clear wins over set on trap
    ctl_cmd(3'b001, 3'b001);
    chk("R8 clear wins", flags, 16'h0244);

    // R10: trap set, single-step request
    ctl_cmd(3'b001, 3'b000);
    instr_done = 1'b1; #1;
    chk("R10 step trap", {15'b0, step_trap}, 16'h0001);
    instr_done = 1'b0; #1;
    chk("R10 no step without done", {15'b0, step_trap}, 16'h0000);

    // R11: direction
    ctl_cmd(3'b100, 3'b000);
    chk("R11 dir down", {15'b0, dir_down}, 16'h0001);
    chk("R12 unused bits zero", flags & 16'hF02A, 16'h0000);
    ctl_cmd(3'b000, 3'b100);
    chk("R11 dir up", {15'b0, dir_down}, 16'h0000);

    // R9: interrupt enable cleared blocks request
    ctl_cmd(3'b000, 3'b010);
    irq_in = 1'b1; #1;
    chk("R9 irq masked", {15'b0, irq_accept}, 16'h0000);
    irq_in = 1'b0;

    // R10: trap cleared
    ctl_cmd(3'b000, 3'b001);
    instr_done = 1'b1; #1;
    chk("R10 trap off", {15'b0, step_trap}, 16'h0000);
    instr_done = 1'b0;

    // R1: reset mid run
    ctl_cmd(3'b111, 3'b000);
    @(negedge clk);
    rst_n = 1'b0; #1;
    chk("R1 reset mid run", flags, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule